// File: doc/BRIEF.md
# Banked GPIO Register File

This block gives software a memory-mapped view of a group of general-purpose pins. The pins are grouped into 32-pin register sets. Each set has a direction word, an output latch and a synchronized input word. The output latch can be written whole, or changed one bit at a time through a write-ones-to-set view and a write-ones-to-clear view. With these two views, a driver can flip single pins without a read-modify-write sequence.

The block drives an output-enable and an output value to each pad. It samples each pad level through a synchronizer chain. The host bus is a plain 32-bit interface:
- A write takes effect on the clock edge where `bus_sel` and `bus_we` are both high.
- Read data is presented combinationally in the same cycle as the read request.

Pin multiplexing, clock gating and edge interrupts are handled by neighbouring blocks.

Top module: `gpio_bank_regs`

## Requirements
- R1: A synchronous active-high reset sets every direction bit to 1, so every pin is an input and `pad_oe` is all zero. It also clears every output latch bit and every synchronizer stage.
- R2: Register set s starts at byte address 0x10 + 0x28*s. Within a set, the words are direction at +0x00, output data at +0x04, set view at +0x08, clear view at +0x0C and input data at +0x10. Pin n belongs to set n/32, at bit n mod 32 of each word.
- R3: A direction bit of 0 makes its pin an output (`pad_oe` bit 1), and a 1 makes it an input. The direction word reads back what was last written.
- R4: A write to the output-data word replaces the whole latch. `pad_out` shows the new value from the next cycle on.
- R5: A write to the set view drives every bit written as 1 to 1. A write to the clear view drives every bit written as 1 to 0. Bits written as 0 keep their value. Both views read back the current latch.
- R6: Each pad level passes two flops before it reaches the input-data word. A level present at clock edge k is readable after edge k+1. This holds whatever the pin's direction is.
- R7: An address outside every mapped word returns zero on a read, and a write to it changes nothing. Unmapped addresses are those below 0x10, those past the last set, offsets +0x14 to +0x27 inside a set, and any address not a multiple of 4.
- R8: A write to an input-data word changes neither the direction nor the output state.
- R9: `bus_rdata` is zero in any cycle that is not a read (`bus_sel` low, or `bus_we` high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pad_in | input | NUM_SETS*32 | Pad levels, asynchronous |
| pad_oe | output | NUM_SETS*32 | Pad output enable, 1 = drive |
| pad_out | output | NUM_SETS*32 | Pad output value |

## Verification
The bench builds the block with its defaults: two register sets and an 8-bit address.

Two sets bring the set boundary between pins 31 and 32 within reach. They also expose the reserved gap between the sets and the top pin 63.

An 8-bit address covers every hole in the map:
- the words below the first set,
- the reserved offsets inside each set,
- the space past the last set,
- misaligned addresses.

A behavioural model decodes addresses arithmetically. It tracks the pad pipeline, and its results are compared with the design on every clock while directed and random traffic runs.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned SET_WIDTH   = 32;
    localparam int unsigned BANK_BASE   = 32'h10;
    localparam int unsigned BANK_STRIDE = 32'h28;
    localparam int unsigned MAPPED_WORDS = 5;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        RK_DIR  = 3'd0,
        RK_OUT  = 3'd1,
        RK_SET  = 3'd2,
        RK_CLR  = 3'd3,
        RK_IN   = 3'd4,
        RK_NONE = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic [SET_WIDTH-1:0] dir;
        logic [SET_WIDTH-1:0] dout;
        logic [SET_WIDTH-1:0] din;
    } bank_view_t;

    function automatic logic [31:0] word_addr(input int unsigned set_i,
                                              input int unsigned word_i);
        return 32'(BANK_BASE + BANK_STRIDE * set_i + 4 * word_i);
    endfunction

    function automatic logic [SET_WIDTH-1:0] next_latch(input reg_kind_e kind,
                                                        input logic [SET_WIDTH-1:0] cur,
                                                        input logic [SET_WIDTH-1:0] wd);
        case (kind)
            RK_OUT:  return wd;
            RK_SET:  return cur | wd;
            RK_CLR:  return cur & ~wd;
            default: return cur;
        endcase
    endfunction

    function automatic logic [SET_WIDTH-1:0] view_word(input reg_kind_e kind,
                                                       input bank_view_t v);
        case (kind)
            RK_DIR:                 return v.dir;
            RK_OUT, RK_SET, RK_CLR: return v.dout;
            RK_IN:                  return v.din;
            default:                return '0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

    if (STAGES == 2) begin : g_lat_chk
        // R6
        sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));
    end

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_SETS = 2,
    parameter int unsigned ADDR_W   = 8,
    localparam int unsigned SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SET_W-1:0]  set_idx,
    output reg_kind_e         kind
);

    always_comb begin
        hit     = 1'b0;
        set_idx = '0;
        kind    = RK_NONE;
        for (int s = 0; s < NUM_SETS; s++) begin
            for (int w = 0; w < MAPPED_WORDS; w++) begin
                if (32'(addr) == word_addr(s, w)) begin
                    hit     = 1'b1;
                    set_idx = SET_W'(s);
                    kind    = reg_kind_e'(3'(w));
                end
            end
        end
    end

endmodule

// File: rtl/gpio_data_bank.sv
module gpio_data_bank
    import gpio_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  reg_kind_e            wr_kind,
    input  logic [SET_WIDTH-1:0] wdata,
    input  logic [SET_WIDTH-1:0] pad_in,
    output bank_view_t           view
);

    logic [SET_WIDTH-1:0] dir_q;
    logic [SET_WIDTH-1:0] out_q;
    logic [SET_WIDTH-1:0] in_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            out_q <= '0;
        end else if (wr_en) begin
            if (wr_kind == RK_DIR) dir_q <= wdata;
            out_q <= next_latch(wr_kind, out_q, wdata);
        end
    end

    gpio_in_sync #(
        .WIDTH  (SET_WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (in_sync)
    );

    assign view = '{dir: dir_q, dout: out_q, din: in_sync};

    // R5
    set_view_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == RK_SET) |=> (out_q == ($past(out_q) | $past(wdata))));

    // R5
    clr_view_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == RK_CLR) |=> (out_q == ($past(out_q) & ~$past(wdata))));

    // R4
    out_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == RK_OUT) |=> (out_q == $past(wdata)));

    // R8
    in_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == RK_IN) |=> ($stable(out_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_SETS = 2,
    parameter int unsigned ADDR_W   = 8,
    localparam int unsigned NPINS   = NUM_SETS * SET_WIDTH,
    localparam int unsigned SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out
);

    logic       dec_hit;
    logic [SET_W-1:0] dec_set;
    reg_kind_e  dec_kind;
    bank_view_t views [NUM_SETS];
    logic [31:0] rd_val;

    gpio_addr_decode #(
        .NUM_SETS (NUM_SETS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .addr    (bus_addr),
        .hit     (dec_hit),
        .set_idx (dec_set),
        .kind    (dec_kind)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_sel && bus_we && dec_hit && (dec_set == SET_W'(s));

        gpio_data_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bank_wr),
            .wr_kind (dec_kind),
            .wdata   (bus_wdata),
            .pad_in  (pad_in[s*SET_WIDTH +: SET_WIDTH]),
            .view    (views[s])
        );

        assign pad_oe[s*SET_WIDTH +: SET_WIDTH]  = ~views[s].dir;
        assign pad_out[s*SET_WIDTH +: SET_WIDTH] = views[s].dout;
    end

    always_comb begin
        rd_val = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (dec_hit && dec_set == SET_W'(s)) rd_val = view_word(dec_kind, views[s]);
        end
        bus_rdata = (bus_sel && !bus_we) ? rd_val : '0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0));

    // R7
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && !dec_hit) |=> ($stable(pad_oe) && $stable(pad_out)));

    // R7
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && !dec_hit) |-> (bus_rdata == '0));

    // R9
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel || bus_we) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_gpio_bank_regs.sv
module sim_gpio_bank_regs;

    localparam int NS = 2;
    localparam int AW = 8;
    localparam int NP = NS * 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst;
    logic          bus_sel, bus_we;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic [NP-1:0] pad_in, pad_oe, pad_out;

    gpio_bank_regs #(.NUM_SETS(NS), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    int vectors = 0;
    int miscompares = 0;
    bit armed = 0;

    logic [31:0]   m_dir [NS];
    logic [31:0]   m_out [NS];
    logic [NP-1:0] m_s1, m_s2;

    // word index 0..4 of a mapped address, or -1; st receives the set
    function automatic int decode_word(input logic [AW-1:0] a, output int st);
        int off;
        st = -1;
        if (int'(a) < 16 || (int'(a) % 4) != 0) return -1;
        off = int'(a) - 16;
        st  = off / 40;
        if (st >= NS) return -1;
        if ((off % 40) / 4 > 4) return -1;
        return (off % 40) / 4;
    endfunction

    function automatic logic [31:0] exp_rdata();
        int st, w;
        if (!bus_sel || bus_we) return '0;
        w = decode_word(bus_addr, st);
        case (w)
            0:       return m_dir[st];
            1, 2, 3: return m_out[st];
            4:       return m_s2[st*32 +: 32];
            default: return '0;
        endcase
    endfunction

    function automatic string rdata_tag();
        int st, w;
        if (!bus_sel || bus_we) return "R9";
        w = decode_word(bus_addr, st);
        case (w)
            0:       return "R2";
            1:       return "R4";
            2, 3:    return "R5";
            4:       return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [NP-1:0] model_oe();
        logic [NP-1:0] v;
        for (int s = 0; s < NS; s++) v[s*32 +: 32] = ~m_dir[s];
        return v;
    endfunction

    function automatic logic [NP-1:0] model_out();
        logic [NP-1:0] v;
        for (int s = 0; s < NS; s++) v[s*32 +: 32] = m_out[s];
        return v;
    endfunction

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        int st, w;
        if (rst) begin
            for (int s = 0; s < NS; s++) begin
                m_dir[s] = '1;
                m_out[s] = '0;
            end
            m_s1 = '0;
            m_s2 = '0;
            armed = 1;
        end else begin
            m_s2 = m_s1;
            m_s1 = pad_in;
            if (bus_sel && bus_we) begin
                w = decode_word(bus_addr, st);
                case (w)
                    0: m_dir[st] = bus_wdata;
                    1: m_out[st] = bus_wdata;
                    2: m_out[st] = m_out[st] | bus_wdata;
                    3: m_out[st] = m_out[st] & ~bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (armed) begin
            check("R3", pad_oe, model_oe());
            check("R4", pad_out, model_out());
            check(rdata_tag(), NP'(bus_rdata), NP'(exp_rdata()));
        end
    end

    task automatic drive(input logic s, input logic w, input logic [AW-1:0] a, input logic [31:0] d);
        @(posedge clk);
        #2;
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1: all inputs, latches clear
        check("R1", pad_oe, '0);
        check("R1", pad_out, '0);
        drive(1, 0, 8'h10, 0);
        @(negedge clk);
        check("R1", NP'(bus_rdata), NP'(32'hFFFF_FFFF));

        // R6: input readback of both sets while pads move
        pad_in = {32'h1234_5678, 32'h9ABC_DEF0};
        drive(1, 0, 8'h20, 0);
        drive(1, 0, 8'h20, 0);
        pad_in = {32'hFFFF_0000, 32'h0000_FFFF};
        drive(1, 0, 8'h48, 0);
        drive(1, 0, 8'h48, 0);
        drive(1, 0, 8'h20, 0);

        // R2/R3: direction in each set
        drive(1, 1, 8'h10, 32'h0000_FFFF);
        drive(1, 1, 8'h38, 32'hF0F0_F0F0);
        drive(1, 0, 8'h10, 0);
        drive(1, 0, 8'h38, 0);

        // R4/R5: latch write, set view, clear view
        drive(1, 1, 8'h14, 32'hA5A5_A5A5);
        drive(1, 1, 8'h18, 32'h0F00_0000);
        drive(1, 1, 8'h1C, 32'h0000_0005);
        drive(1, 0, 8'h18, 0);
        drive(1, 0, 8'h1C, 0);
        drive(1, 1, 8'h40, 32'h8000_0001);
        drive(1, 1, 8'h38, 32'h0);
        drive(1, 1, 8'h44, 32'h0000_0001);
        drive(1, 0, 8'h3C, 0);
        // R6: input reads the pad even with the pin as an output
        pad_in = {32'h0, 32'h5555_5555};
        drive(1, 0, 8'h20, 0);
        drive(1, 0, 8'h20, 0);
        drive(1, 0, 8'h20, 0);

        // R7: unmapped reads and writes
        drive(1, 1, 8'h00, 32'hFFFF_FFFF);
        drive(1, 1, 8'h0C, 32'hFFFF_FFFF);
        drive(1, 1, 8'h24, 32'hFFFF_FFFF);
        drive(1, 1, 8'h4C, 32'hFFFF_FFFF);
        drive(1, 1, 8'h60, 32'hFFFF_FFFF);
        drive(1, 1, 8'h15, 32'hFFFF_FFFF);
        drive(1, 0, 8'h24, 0);
        drive(1, 0, 8'h11, 0);
        drive(1, 0, 8'h60, 0);
        drive(1, 0, 8'h0C, 0);

        // R8: writes to the input words touch nothing
        drive(1, 1, 8'h20, 32'hFFFF_FFFF);
        drive(1, 1, 8'h48, 32'h0000_0000);
        drive(0, 0, 8'h14, 0);
        @(negedge clk);
        check("R8", pad_out, model_out());
        check("R8", pad_oe, model_oe());

        // R9: write cycle and idle cycle give zero read data
        drive(0, 0, 8'h14, 0);
        drive(1, 1, 8'h14, 32'h1);

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            pad_in = {$urandom, $urandom};
            drive(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                  AW'($urandom_range(0, 127)), $urandom);
        end
        drive(0, 0, '0, '0);
        @(negedge clk);
        #1;
        finish_run();
    end

endmodule